// File: doc/BRIEF.md
# Write-back data cache with freeze and bypass modes

This block is a small 4-way set-associative data cache. It sits between a processor-side request port and an external memory port. It keeps lines of 128 bytes and serves word reads and word writes. Writes to cacheable addresses stay in the cache and mark the line dirty. A dirty line goes back to external memory only when it is chosen as the victim for a new line. Each external transfer is one 32-bit word, moved under a request/ready handshake.

A two-bit mode input sets the behaviour:

- **Normal** (0) allocates lines on a miss.
- **Freeze** (1) serves hits as usual. A miss becomes a single external word access and leaves the cache untouched. This keeps a working set resident while one-off code runs.
- **Bypass** (2, and also 3) sends every access to external memory and neither reads nor changes the cache.

A per-access cacheable flag comes from an address-attribute lookup outside the block. When it is low, the access goes to external memory in every mode, so repeated reads of device registers always return fresh values.

The processor holds its request stable until `cpu_ready` pulses for one cycle. On a read, `cpu_rdata` is valid during that pulse.

Top module: `cache_wb_freeze`

## Requirements
- R1: A line fill reads the 32 words of the missing 128-byte line from external memory in ascending word order and ends at line offset 0x7C. The external address and direction stay unchanged while a transfer waits for `ext_ready`.
- R2: The first cacheable access in normal mode (mode 0) to a line that is not resident fills that line. A read then returns the external memory word.
- R3: A cacheable access that hits makes no external transfer. `cpu_ready` is seen high in the second cycle after the request is first sampled.
- R4: A write hit updates only the cache. External memory keeps its old value, and a later read of the word returns the written data with no external traffic.
- R5: A dirty victim is written back as 32 external word writes to its old address before the new line is filled. A clean victim makes no external write.
- R6: In freeze mode (mode 1), read and write hits behave as in normal mode. A miss becomes exactly one external word access, which is a read for a read and a write for a write. A miss changes no tag, valid, dirty or replacement state, so repeating it misses again.
- R7: In bypass mode (mode 2 or 3), every access is exactly one external word access. Cached data, including dirty data, is neither returned nor changed.
- R8: An access with `cpu_cacheable` low is exactly one external word access in every mode. It returns the current memory value even when the line is resident.
- R9: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, the victim comes from a 3-bit tree pseudo-LRU that is updated on every hit.
- R10: A write miss in normal mode fills the line, then merges the write word into it and marks the line dirty. External memory is not written.
- R11: `cpu_ready` is a one-cycle pulse per request. It is low whenever `ext_req` is high, which includes every fill and write-back.
- R12: After a synchronous active-high reset, `cpu_ready` and `ext_req` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 normal, 1 freeze, 2 or 3 bypass; sampled with the request |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_cacheable | input | 1 | Address attribute: 1 cacheable |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| ext_req | output | 1 | External word transfer request |
| ext_we | output | 1 | External transfer is a write |
| ext_addr | output | 32 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_ready | input | 1 | Transfer completes on this cycle |
| ext_rdata | input | 32 | External read data, valid with `ext_ready` |

## Verification
The first pattern fills one set's four ways in turn and then forces two evictions. Which lines still hit afterwards separates invalid-first choice and tree pseudo-LRU from round-robin or FIFO replacement, and the written-back memory word shows that a dirty victim was flushed. Freeze, bypass and non-cacheable accesses are each run against both a resident line and a missing one. Counting external reads and writes, and comparing against memory contents changed behind the cache, tells allocation, single-word pass-through and ignored cache contents apart. Write misses in normal and freeze modes are compared to separate allocate-and-merge from a plain external write.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_FREEZE = 2'd1;
  localparam logic [1:0] MODE_BYPASS = 2'd2;
  localparam int         NUM_WAYS    = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_EXT, S_RESP
  } cwb_state_t;
endpackage

// File: rtl/cwb_plru.sv
// Tree pseudo-LRU for one 4-way set: bit0 picks the half, bit1/bit2 the way within it.
module cwb_plru (
  input  logic [2:0] bits_in,
  input  logic [1:0] touch_way,
  output logic [1:0] victim,
  output logic [2:0] bits_out
);
  always_comb begin
    victim = bits_in[0] ? (bits_in[2] ? 2'd3 : 2'd2)
                        : (bits_in[1] ? 2'd1 : 2'd0);
    bits_out = bits_in;
    if (!touch_way[1]) begin
      bits_out[0] = 1'b1;
      bits_out[1] = ~touch_way[0];
    end else begin
      bits_out[0] = 1'b0;
      bits_out[2] = ~touch_way[0];
    end
  end
endmodule

// File: rtl/cwb_data_ram.sv
module cwb_data_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cache_wb_freeze.sv
module cache_wb_freeze
  import cwb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_cacheable,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ready,
  input  logic [DATA_W-1:0] ext_rdata
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int WORDS  = LINE_BYTES / (DATA_W/8);
  localparam int WRD_W  = $clog2(WORDS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int ENT_W  = IDX_W + WAY_W;
  localparam int NENT   = SETS * NUM_WAYS;
  localparam int DEPTH  = NENT * WORDS;
  localparam int RAM_AW = $clog2(DEPTH);
  localparam logic [WRD_W-1:0] LAST = WRD_W'(WORDS - 1);

  cwb_state_t        st;
  logic              r_we, r_cache;
  logic [1:0]        r_mode;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [WRD_W-1:0]  cnt;
  logic [WAY_W-1:0]  vway;

  logic [TAG_W-1:0]  tag_q [NENT];
  logic [NENT-1:0]   valid_q, dirty_q;
  logic [2:0]        plru_q [SETS];

  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [WRD_W-1:0]  r_word;
  assign r_idx  = r_addr[OFF_W +: IDX_W];
  assign r_tag  = r_addr[ADDR_W-1 -: TAG_W];
  assign r_word = r_addr[BYTE_W +: WRD_W];

  // Tag compare, one comparator per way
  logic [NUM_WAYS-1:0] hit_vec;
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign hit_vec[w] = valid_q[{r_idx, WAY_W'(w)}] &&
                        (tag_q[{r_idx, WAY_W'(w)}] == r_tag);
  end

  logic             hit, any_inv;
  logic [WAY_W-1:0] hit_way, inv_way, plru_vic, victim;
  logic [2:0]       plru_next;
  always_comb begin
    hit = 1'b0; hit_way = '0; any_inv = 1'b0; inv_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) begin hit = 1'b1; hit_way = WAY_W'(w); end
    end
    for (int w = NUM_WAYS-1; w >= 0; w--) begin
      if (!valid_q[{r_idx, WAY_W'(w)}]) begin any_inv = 1'b1; inv_way = WAY_W'(w); end
    end
  end

  cwb_plru u_plru (
    .bits_in(plru_q[r_idx]), .touch_way(hit_way),
    .victim(plru_vic), .bits_out(plru_next)
  );
  assign victim = any_inv ? inv_way : plru_vic;

  logic uncached;
  assign uncached = (r_mode >= MODE_BYPASS) || !r_cache;

  // Data array port steering
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {r_idx, hit_way, r_word};
    ram_wdata = r_wdata;
    if (st == S_LOOK && !uncached && hit && r_we) ram_we = 1'b1;
    if (st == S_FILL && ext_ready) begin
      ram_we    = 1'b1;
      ram_waddr = {r_idx, vway, cnt};
      ram_wdata = ext_rdata;
    end
    ram_raddr = (st == S_WB) ? {r_idx, vway, cnt} : {r_idx, hit_way, r_word};
  end

  cwb_data_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  // External port, driven from state registers only
  always_comb begin
    ext_req   = (st == S_WB) || (st == S_FILL) || (st == S_EXT);
    ext_we    = (st == S_WB) || (st == S_EXT && r_we);
    ext_wdata = (st == S_WB) ? ram_rdata : r_wdata;
    case (st)
      S_WB:    ext_addr = {tag_q[{r_idx, vway}], r_idx, cnt, {BYTE_W{1'b0}}};
      S_FILL:  ext_addr = {r_tag, r_idx, cnt, {BYTE_W{1'b0}}};
      default: ext_addr = r_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      cnt       <= '0;
      vway      <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= 3'b000;
    end else begin
      cpu_ready <= 1'b0;
      case (st)
        S_IDLE: if (cpu_req) begin
          r_we <= cpu_we; r_addr <= cpu_addr; r_wdata <= cpu_wdata;
          r_cache <= cpu_cacheable; r_mode <= mode;
          st <= S_LOOK;
        end
        S_LOOK: begin
          if (uncached) st <= S_EXT;
          else if (hit) begin
            if (r_we) dirty_q[{r_idx, hit_way}] <= 1'b1;
            else      cpu_rdata <= ram_rdata;
            plru_q[r_idx] <= plru_next;
            cpu_ready <= 1'b1;
            st <= S_RESP;
          end else if (r_mode == MODE_FREEZE) st <= S_EXT;
          else begin
            vway <= victim;
            cnt  <= '0;
            st   <= dirty_q[{r_idx, victim}] ? S_WB : S_FILL;
          end
        end
        S_WB: if (ext_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FILL;
        end
        S_FILL: if (ext_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            tag_q[{r_idx, vway}]   <= r_tag;
            valid_q[{r_idx, vway}] <= 1'b1;
            dirty_q[{r_idx, vway}] <= 1'b0;
            st <= S_LOOK;
          end
        end
        S_EXT: if (ext_ready) begin
          if (!r_we) cpu_rdata <= ext_rdata;
          cpu_ready <= 1'b1;
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Assertions
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> !cpu_ready);
  p_ext_hold_r1: assert property (@(posedge clk) disable iff (rst)
    ext_req && !ext_ready |=> ext_req && $stable(ext_addr) && $stable(ext_we));
  p_fill_step_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_FILL && ext_ready && cnt != LAST) |=>
      ext_addr == $past(ext_addr) + ADDR_W'(DATA_W/8));
  p_wb_dirty_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_WB) |-> valid_q[{r_idx, vway}] && dirty_q[{r_idx, vway}]);
  p_ext_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXT) |=> $stable(valid_q) && $stable(dirty_q));
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && hit && !uncached) |=> !ext_req && cpu_ready);
endmodule

// File: tb/cache_wb_freeze_tb.sv
`timescale 1ns/1ps
module cache_wb_freeze_tb;
  logic        clk = 0, rst = 1;
  logic [1:0]  mode = 0;
  logic        cpu_req = 0, cpu_we = 0, cpu_cacheable = 1;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        ext_req, ext_we, ext_ready;
  logic [31:0] ext_addr, ext_wdata, ext_rdata;

  int errors = 0, checks = 0, cycles = 0;
  int n_rd = 0, n_wr = 0, bad_overlap = 0, bad_pulse = 0;
  logic [31:0] last_rd_addr = 0, last_wr_addr = 0;
  logic        prev_ready = 0;
  logic [31:0] mem [2048];

  always #2 clk = ~clk;

  cache_wb_freeze u_dut (
    .clk(clk), .rst(rst), .mode(mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_cacheable(cpu_cacheable),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .ext_req(ext_req),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_ready(ext_ready), .ext_rdata(ext_rdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hC0DE0000 ^ (a >> 2);
  endfunction

  // External memory: ready one cycle after a request is seen
  always @(posedge clk) begin
    if (rst) ext_ready <= 0;
    else if (ext_ready) ext_ready <= 0;
    else if (ext_req) begin
      ext_ready <= 1;
      ext_rdata <= mem[ext_addr[12:2]];
      if (ext_we) begin
        mem[ext_addr[12:2]] <= ext_wdata; n_wr <= n_wr + 1; last_wr_addr <= ext_addr;
      end else begin
        n_rd <= n_rd + 1; last_rd_addr <= ext_addr;
      end
    end
  end

  // Handshake monitor for R11
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if (cpu_ready && ext_req) bad_overlap <= bad_overlap + 1;
      if (cpu_ready && prev_ready) bad_pulse <= bad_pulse + 1;
      prev_ready <= cpu_ready;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic cac, input logic [1:0] md,
                        output logic [31:0] rd, output int cyc, output int drd, output int dwr);
    int r0, w0;
    @(negedge clk);
    r0 = n_rd; w0 = n_wr;
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_cacheable = cac; mode = md;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_ready);
    rd = cpu_rdata; cpu_req = 0;
    drd = n_rd - r0; dwr = n_wr - w0;
  endtask

  logic [31:0] rd; int cyc, drd, dwr;

  task automatic t_reset;
    chk("R12", "cpu_ready after reset", {31'b0, cpu_ready}, 0);
    chk("R12", "ext_req after reset", {31'b0, ext_req}, 0);
  endtask

  task automatic t_first_miss;
    access(0, 32'h4, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R2", "first read data", rd, pat(32'h4));
    chk("R1", "fill word reads", drd, 32);
    chk("R1", "fill last address", last_rd_addr, 32'h7C);
    chk("R2", "fill writes", dwr, 0);
  endtask

  task automatic t_hit;
    access(0, 32'h10, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R3", "hit data", rd, pat(32'h10));
    chk("R3", "hit ext traffic", drd + dwr, 0);
    chk("R3", "hit latency", cyc, 2);
  endtask

  task automatic t_write_hit;
    access(1, 32'h8, 32'h11112222, 1, 0, rd, cyc, drd, dwr);
    chk("R4", "write hit ext traffic", drd + dwr, 0);
    chk("R4", "memory untouched", mem[2], pat(32'h8));
    access(0, 32'h8, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R4", "read back", rd, 32'h11112222);
    chk("R4", "read back ext traffic", drd + dwr, 0);
  endtask

  task automatic t_evict;
    access(0, 32'h200, 0, 1, 0, rd, cyc, drd, dwr); chk("R9", "fill way1", drd, 32);
    access(0, 32'h400, 0, 1, 0, rd, cyc, drd, dwr); chk("R9", "fill way2", drd, 32);
    access(0, 32'h600, 0, 1, 0, rd, cyc, drd, dwr); chk("R9", "fill way3", drd, 32);
    chk("R9", "no write back into invalid ways", dwr, 0);
    // PLRU now names way 0 (dirty line of tag 0)
    access(0, 32'h800, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R5", "write-back words", dwr, 32);
    chk("R5", "write-back last address", last_wr_addr, 32'h7C);
    chk("R5", "written-back word", mem[2], 32'h11112222);
    chk("R5", "new line data", rd, pat(32'h800));
    access(0, 32'h204, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R9", "tag1 still resident", drd, 0);
    // PLRU now names way 2 (clean tag 2)
    access(0, 32'h8, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R5", "clean victim no write", dwr, 0);
    chk("R5", "refetched flushed data", rd, 32'h11112222);
    access(0, 32'h600, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R9", "tag3 kept", drd, 0);
    access(0, 32'h400, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R9", "tag2 evicted", drd, 32);
  endtask

  task automatic t_freeze;
    access(0, 32'h80, 0, 1, 0, rd, cyc, drd, dwr); chk("R2", "set1 fill", drd, 32);
    access(0, 32'h84, 0, 1, 1, rd, cyc, drd, dwr);
    chk("R6", "freeze read hit traffic", drd + dwr, 0);
    chk("R6", "freeze read hit data", rd, pat(32'h84));
    access(1, 32'h88, 32'hAAAA5555, 1, 1, rd, cyc, drd, dwr);
    chk("R6", "freeze write hit traffic", drd + dwr, 0);
    access(0, 32'h280, 0, 1, 1, rd, cyc, drd, dwr);
    chk("R6", "freeze read miss reads", drd, 1);
    chk("R6", "freeze read miss data", rd, pat(32'h280));
    access(0, 32'h280, 0, 1, 1, rd, cyc, drd, dwr);
    chk("R6", "freeze miss not allocated", drd, 1);
    access(1, 32'h288, 32'h12345678, 1, 1, rd, cyc, drd, dwr);
    chk("R6", "freeze write miss writes", dwr, 1);
    chk("R6", "freeze write miss reads", drd, 0);
    chk("R6", "freeze write miss memory", mem[32'h288 >> 2], 32'h12345678);
    access(0, 32'h88, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R6", "freeze write hit kept", rd, 32'hAAAA5555);
    chk("R6", "set1 still resident", drd, 0);
  endtask

  task automatic t_bypass;
    access(0, 32'h88, 0, 1, 2, rd, cyc, drd, dwr);
    chk("R7", "bypass read count", drd, 1);
    chk("R7", "bypass ignores dirty copy", rd, pat(32'h88));
    access(1, 32'h8C, 32'h5A5A5A5A, 1, 2, rd, cyc, drd, dwr);
    chk("R7", "bypass write count", dwr, 1);
    chk("R7", "bypass write memory", mem[32'h8C >> 2], 32'h5A5A5A5A);
    access(0, 32'h8C, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R7", "cache unchanged by bypass", rd, pat(32'h8C));
    chk("R7", "cache unchanged traffic", drd, 0);
    access(0, 32'h84, 0, 1, 3, rd, cyc, drd, dwr);
    chk("R7", "mode 3 bypass read", drd, 1);
  endtask

  task automatic t_noncache;
    access(0, 32'h100, 0, 0, 0, rd, cyc, drd, dwr);
    chk("R8", "uncached read count", drd, 1);
    chk("R8", "uncached read data", rd, pat(32'h100));
    @(negedge clk); mem[32'h100 >> 2] = 32'hFEEDF00D;
    access(0, 32'h100, 0, 0, 0, rd, cyc, drd, dwr);
    chk("R8", "uncached repeat fresh", rd, 32'hFEEDF00D);
    chk("R8", "uncached repeat count", drd, 1);
    access(0, 32'h104, 0, 1, 0, rd, cyc, drd, dwr); chk("R2", "set2 fill", drd, 32);
    @(negedge clk); mem[32'h104 >> 2] = 32'h0BADCAFE;
    access(0, 32'h104, 0, 0, 1, rd, cyc, drd, dwr);
    chk("R8", "uncached over resident line", rd, 32'h0BADCAFE);
    chk("R8", "uncached resident count", drd, 1);
    access(0, 32'h104, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R8", "cached copy intact", rd, pat(32'h104));
  endtask

  task automatic t_write_alloc;
    access(1, 32'h184, 32'hBEEF0001, 1, 0, rd, cyc, drd, dwr);
    chk("R10", "write miss fill", drd, 32);
    chk("R10", "write miss no ext write", dwr, 0);
    chk("R10", "memory untouched", mem[32'h184 >> 2], pat(32'h184));
    access(0, 32'h184, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R10", "merged word", rd, 32'hBEEF0001);
    access(0, 32'h180, 0, 1, 0, rd, cyc, drd, dwr);
    chk("R10", "neighbour word", rd, pat(32'h180));
    chk("R10", "line resident", drd, 0);
  endtask

  task automatic t_ready;
    chk("R11", "ready during ext transfer", bad_overlap, 0);
    chk("R11", "ready longer than one cycle", bad_pulse, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = pat(32'(i) << 2);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_first_miss;
    t_hit;
    t_write_hit;
    t_evict;
    t_freeze;
    t_bypass;
    t_noncache;
    t_write_alloc;
    t_ready;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule